// File: doc/BRIEF.md
# Watch-Mode Standby Sequencer

This block steers a microcontroller into and out of its watch standby mode. Software asks for watch mode by writing a one-cycle request. The request is honoured only while the system runs from one of the two slow oscillators. In watch mode the block removes the CPU and peripheral clock enables. It keeps the slow oscillators and the watch prescaler running, and drives the pad control lines. A sample of the pin-policy input taken on entry decides whether the pads hold their levels or float to high impedance, with weak pull-ups left as configured.

A watch-timer interrupt or an external interrupt wakes the block. If flash recovery is needed, meaning deep standby is not selected and code is not running from RAM, the block first spends a fixed number of cycles in a sleep-like recovery state. In that state only the peripheral clock runs. It then returns to run and gives a one-cycle completion pulse. A system reset forces run with all clocks enabled. The recovery wait is also applied on the way out of reset. The block has no reset or clear output, so register and RAM contents are never touched by entry or exit.

Top module: `watch_standby_seq`

## Requirements
- R1: A `watch_req` pulse moves the block from run to watch only when `clk_mode` is 3'b000 (slow crystal) or 3'b100 (slow RC). With any other code the request is ignored and `in_watch` stays 0.
- R2: While in watch, `cpu_clk_en` and `periph_clk_en` are 0, and `subosc_en` and `prescaler_en` are 1.
- R3: `pin_hiz_sel` is sampled on the entry cycle. If the sample is 0, watch drives `pin_hold`=1 and `pin_hiz`=0. If it is 1, watch drives `pin_hiz`=1 and `pin_hold`=0. Outside watch both are 0.
- R4: Only `watch_irq` or `ext_irq` ends watch. A further `watch_req` during watch has no effect.
- R5: With `deep_stby`=0 and `ram_exec`=0, a wake moves the block to recovery. Recovery lasts exactly RECOV_CYCLES cycles, with `in_recover`=1, `cpu_clk_en`=0 and `periph_clk_en`=1. Wake inputs are ignored during recovery.
- R6: With `deep_stby`=1 or `ram_exec`=1, a wake returns the block to run on the next cycle, with no recovery.
- R7: In watch, `subcr_en` is 1 if watch was entered from mode 3'b100 or if `wdt_stby_en` is 1. Otherwise it is 0. Outside watch `subcr_en` is 1.
- R8: If a wake input is high in the same cycle as an accepted-mode `watch_req`, the block stays in run.
- R9: `wake_done` is a one-cycle pulse. It appears in the first run cycle after watch or recovery, and at no other time.
- R10: While `rst_n` is low the block is in run, with all clock enables at 1 and both pin controls at 0. In the first cycle after release it either enters recovery (if R5's condition holds then) or stays in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running slow clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clk_mode | input | 3 | Current clock-mode code |
| watch_req | input | 1 | One-cycle software request for watch mode |
| pin_hiz_sel | input | 1 | Pad policy: 0 hold, 1 high impedance |
| deep_stby | input | 1 | 1 skips the flash-recovery wait |
| ram_exec | input | 1 | 1 when code runs from RAM (skips wait) |
| wdt_stby_en | input | 1 | Keep slow RC clock for the watchdog in watch |
| watch_irq | input | 1 | Watch-timer interrupt (wake) |
| ext_irq | input | 1 | External interrupt (wake) |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| subosc_en | output | 1 | Slow crystal oscillator enable |
| subcr_en | output | 1 | Slow RC oscillator enable |
| prescaler_en | output | 1 | Watch prescaler enable |
| pin_hold | output | 1 | Pads keep their output levels |
| pin_hiz | output | 1 | Pads float (pull-ups as configured) |
| in_watch | output | 1 | Block is in watch |
| in_recover | output | 1 | Block is in the flash-recovery sleep |
| wake_done | output | 1 | One-cycle pulse on return to run |

## Verification
The assertions assume that `watch_req` is a single-cycle pulse. They also assume that `deep_stby` and `ram_exec` only matter on the cycle they are sampled, so they may change freely at other times. The stimulus changes inputs only between clock edges. It holds the wake inputs low except for deliberate one- or two-cycle pulses. It also applies reset only as a level lasting at least one edge, so that the behavioural model and the design see the same sampled values.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WATCH   = 2'd1,
    ST_RECOVER = 2'd2
  } wsq_state_e;

  localparam logic [2:0] MODE_SUBOSC = 3'b000;
  localparam logic [2:0] MODE_SUBCR  = 3'b100;

  // Watch entry is legal only from a slow-oscillator clock mode.
  function automatic logic mode_allows_watch(input logic [2:0] mode);
    return (mode == MODE_SUBOSC) || (mode == MODE_SUBCR);
  endfunction

  // The flash needs its recovery wait unless deep standby is set or code runs from RAM.
  function automatic logic needs_flash_wait(input logic deep, input logic ram);
    return !deep && !ram;
  endfunction

endpackage

// File: rtl/wsq_entry_gate.sv
module wsq_entry_gate
  import wsq_pkg::*;
(
  input  logic       watch_req,
  input  logic [2:0] clk_mode,
  input  logic       wake_evt,
  input  logic       in_run,
  output logic       enter_ok,
  output logic       enter_cr
);

  logic mode_ok;

  assign mode_ok  = mode_allows_watch(clk_mode);
  // A concurrent wake cancels the request (wake wins).
  assign enter_ok = in_run && watch_req && mode_ok && !wake_evt;
  assign enter_cr = (clk_mode == MODE_SUBCR);

endmodule

// File: rtl/wsq_recover_timer.sv
module wsq_recover_timer #(
  parameter int RECOV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  output logic expired
);

  localparam int CW = $clog2(RECOV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RECOV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (active && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = active && (cnt_q == '0);

  initial begin
    assert_cycles_positive_R5: assert (RECOV_CYCLES >= 1);
  end

  // The count never runs while a new load is being applied.
  assert_no_load_when_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

endmodule

// File: rtl/wsq_clk_ctrl.sv
module wsq_clk_ctrl
  import wsq_pkg::*;
(
  input  wsq_state_e state,
  input  logic       cap_cr,
  input  logic       cap_hiz,
  input  logic       wdt_stby_en,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       subosc_en,
  output logic       subcr_en,
  output logic       prescaler_en,
  output logic       pin_hold,
  output logic       pin_hiz
);

  logic watching;

  assign watching      = (state == ST_WATCH);
  assign cpu_clk_en    = (state == ST_RUN);
  assign periph_clk_en = !watching;
  assign subosc_en     = 1'b1;
  assign prescaler_en  = 1'b1;
  assign subcr_en      = !watching || cap_cr || wdt_stby_en;
  assign pin_hold      = watching && !cap_hiz;
  assign pin_hiz       = watching && cap_hiz;

endmodule

// File: rtl/watch_standby_seq.sv
module watch_standby_seq
  import wsq_pkg::*;
#(
  parameter int RECOV_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_mode,
  input  logic       watch_req,
  input  logic       pin_hiz_sel,
  input  logic       deep_stby,
  input  logic       ram_exec,
  input  logic       wdt_stby_en,
  input  logic       watch_irq,
  input  logic       ext_irq,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       subosc_en,
  output logic       subcr_en,
  output logic       prescaler_en,
  output logic       pin_hold,
  output logic       pin_hiz,
  output logic       in_watch,
  output logic       in_recover,
  output logic       wake_done
);

  localparam int LW = $clog2(RECOV_CYCLES + 2);

  wsq_state_e state_q, state_d;
  logic boot_pend_q, cap_cr_q, cap_hiz_q, done_q;
  logic wake_evt, need_wait, enter_ok, enter_cr, rec_load, rec_expired;
  logic run_idle;

  assign wake_evt  = watch_irq | ext_irq;
  assign need_wait = needs_flash_wait(deep_stby, ram_exec);
  assign run_idle  = (state_q == ST_RUN) && !boot_pend_q;

  wsq_entry_gate u_gate (
    .watch_req (watch_req),
    .clk_mode  (clk_mode),
    .wake_evt  (wake_evt),
    .in_run    (run_idle),
    .enter_ok  (enter_ok),
    .enter_cr  (enter_cr)
  );

  always_comb begin
    state_d  = state_q;
    rec_load = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (boot_pend_q) begin
          if (need_wait) begin
            state_d  = ST_RECOVER;
            rec_load = 1'b1;
          end
        end else if (enter_ok) begin
          state_d = ST_WATCH;
        end
      end
      ST_WATCH: begin
        if (wake_evt) begin
          if (need_wait) begin
            state_d  = ST_RECOVER;
            rec_load = 1'b1;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RECOVER: begin
        if (rec_expired) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      boot_pend_q <= 1'b1;
      cap_cr_q    <= 1'b0;
      cap_hiz_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      boot_pend_q <= 1'b0;
      if (state_q == ST_RUN && state_d == ST_WATCH) begin
        cap_cr_q  <= enter_cr;
        cap_hiz_q <= pin_hiz_sel;
      end
      done_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
    end
  end

  wsq_recover_timer #(.RECOV_CYCLES(RECOV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rec_load),
    .active  (state_q == ST_RECOVER),
    .expired (rec_expired)
  );

  wsq_clk_ctrl u_ctrl (
    .state         (state_q),
    .cap_cr        (cap_cr_q),
    .cap_hiz       (cap_hiz_q),
    .wdt_stby_en   (wdt_stby_en),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .subosc_en     (subosc_en),
    .subcr_en      (subcr_en),
    .prescaler_en  (prescaler_en),
    .pin_hold      (pin_hold),
    .pin_hiz       (pin_hiz)
  );

  assign in_watch   = (state_q == ST_WATCH);
  assign in_recover = (state_q == ST_RECOVER);
  assign wake_done  = done_q;

  // Length of the current recovery stay, kept for the checks below.
  logic [LW-1:0] rec_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rec_len_q <= '0;
    else if (in_recover) rec_len_q <= rec_len_q + 1'b1;
    else                 rec_len_q <= '0;
  end

  assert_entry_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_watch) |-> ($past(clk_mode) == 3'b000 || $past(clk_mode) == 3'b100));

  assert_watch_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_watch |-> (!cpu_clk_en && !periph_clk_en && subosc_en && prescaler_en));

  assert_pins_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_watch |-> (pin_hold ^ pin_hiz));

  assert_pins_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_watch |-> (!pin_hold && !pin_hiz));

  assert_wake_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_watch) |-> $past(watch_irq || ext_irq));

  assert_recover_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_recover |-> (int'(rec_len_q) < RECOV_CYCLES));

  assert_recover_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_recover) |-> (int'($past(rec_len_q)) == RECOV_CYCLES - 1));

  assert_recover_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_recover |-> (!cpu_clk_en && periph_clk_en && !in_watch));

  assert_direct_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_watch && (watch_irq || ext_irq) && (deep_stby || ram_exec)) |=> cpu_clk_en);

  assert_wdt_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_watch && wdt_stby_en) |-> subcr_en);

  assert_wake_beats_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && (watch_irq || ext_irq)) |=> !in_watch);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (cpu_clk_en && $past(in_watch || in_recover)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

endmodule

// File: tb/watch_standby_seq_tb.sv
module watch_standby_seq_tb;

  localparam int N = 8;
  localparam int ST_RUN = 0, ST_WATCH = 1, ST_REC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] clk_mode = 3'b000;
  logic watch_req = 0, pin_hiz_sel = 0, deep_stby = 0, ram_exec = 0;
  logic wdt_stby_en = 0, watch_irq = 0, ext_irq = 0;
  logic cpu_clk_en, periph_clk_en, subosc_en, subcr_en, prescaler_en;
  logic pin_hold, pin_hiz, in_watch, in_recover, wake_done;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_st = ST_RUN;
  int m_cnt = 0;
  bit m_boot = 1, m_cr = 0, m_hiz = 0, m_done = 0;

  always #5 clk = ~clk;

  watch_standby_seq #(.RECOV_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .watch_req(watch_req),
    .pin_hiz_sel(pin_hiz_sel), .deep_stby(deep_stby), .ram_exec(ram_exec),
    .wdt_stby_en(wdt_stby_en), .watch_irq(watch_irq), .ext_irq(ext_irq),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .subosc_en(subosc_en),
    .subcr_en(subcr_en), .prescaler_en(prescaler_en), .pin_hold(pin_hold),
    .pin_hiz(pin_hiz), .in_watch(in_watch), .in_recover(in_recover),
    .wake_done(wake_done)
  );

  always @(posedge clk) begin
    bit wake, wait_needed;
    wake = watch_irq || ext_irq;
    wait_needed = !deep_stby && !ram_exec;
    if (!rst_n) begin
      m_st = ST_RUN; m_boot = 1; m_cr = 0; m_hiz = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_st == ST_RUN) begin
        if (m_boot) begin
          if (wait_needed) begin m_st = ST_REC; m_cnt = N; end
        end else if (watch_req && !wake && (clk_mode == 3'b000 || clk_mode == 3'b100)) begin
          m_st = ST_WATCH; m_cr = (clk_mode == 3'b100); m_hiz = pin_hiz_sel;
        end
      end else if (m_st == ST_WATCH) begin
        if (wake) begin
          if (wait_needed) begin m_st = ST_REC; m_cnt = N; end
          else begin m_st = ST_RUN; m_done = 1; end
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_st = ST_RUN; m_done = 1; end
      end
      m_boot = 0;
    end
  end

  task automatic ck(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit w;
    w = (m_st == ST_WATCH);
    ck("R2 R10 cpu_clk_en", cpu_clk_en, m_st == ST_RUN);
    ck("R2 R5 periph_clk_en", periph_clk_en, !w);
    ck("R2 subosc_en", subosc_en, 1'b1);
    ck("R2 prescaler_en", prescaler_en, 1'b1);
    ck("R7 subcr_en", subcr_en, !w || m_cr || wdt_stby_en);
    ck("R3 pin_hold", pin_hold, w && !m_hiz);
    ck("R3 pin_hiz", pin_hiz, w && m_hiz);
    ck("R1 R4 in_watch", in_watch, w);
    ck("R5 in_recover", in_recover, m_st == ST_REC);
    ck("R9 wake_done", wake_done, m_done);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      compare_all();
      watch_req = 0; watch_irq = 0; ext_irq = 0;
    end
  endtask

  initial begin
    #300000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state
    cyc(2);
    ck("R10 reset cpu", cpu_clk_en, 1'b1);
    ck("R10 reset periph", periph_clk_en, 1'b1);
    rst_n = 1;
    cyc(1);
    ck("R10 boot recovery", in_recover, 1'b1);
    cyc(N + 2);
    // R1: bad clock mode ignored
    clk_mode = 3'b010; watch_req = 1;
    cyc(2);
    ck("R1 bad mode ignored", in_watch, 1'b0);
    // enter from slow crystal, hold pins, wake with watch irq, recovery
    clk_mode = 3'b000; pin_hiz_sel = 0; watch_req = 1;
    cyc(1);
    ck("R1 entry", in_watch, 1'b1);
    pin_hiz_sel = 1;
    cyc(3);
    ck("R3 sampled hold", pin_hold, 1'b1);
    watch_req = 1; clk_mode = 3'b100;
    cyc(2);
    ck("R4 request in watch ignored", in_watch, 1'b1);
    watch_irq = 1;
    cyc(1);
    ck("R5 recover entered", in_recover, 1'b1);
    ext_irq = 1;
    cyc(N + 2);
    // enter from slow RC, float pins, ext wake with deep standby
    clk_mode = 3'b100; pin_hiz_sel = 1; watch_req = 1;
    cyc(3);
    ck("R7 subcr kept", subcr_en, 1'b1);
    deep_stby = 1; ext_irq = 1;
    cyc(1);
    ck("R6 direct return", cpu_clk_en, 1'b1);
    ck("R9 done pulse", wake_done, 1'b1);
    cyc(1);
    ck("R9 done single", wake_done, 1'b0);
    deep_stby = 0;
    // slow crystal with watchdog bit toggling, RAM exec wake
    clk_mode = 3'b000; pin_hiz_sel = 0; watch_req = 1;
    cyc(2);
    ck("R7 subcr off", subcr_en, 1'b0);
    wdt_stby_en = 1;
    cyc(2);
    ck("R7 subcr wdt", subcr_en, 1'b1);
    wdt_stby_en = 0; ram_exec = 1; watch_irq = 1;
    cyc(1);
    ck("R6 ram exec direct", in_recover, 1'b0);
    ram_exec = 0;
    cyc(2);
    // R8: wake same cycle as request
    watch_req = 1; ext_irq = 1;
    cyc(2);
    ck("R8 wake wins", in_watch, 1'b0);
    // reset during watch, then boot with deep standby
    watch_req = 1;
    cyc(3);
    rst_n = 0;
    cyc(2);
    ck("R10 reset in watch", cpu_clk_en, 1'b1);
    deep_stby = 1; rst_n = 1;
    cyc(2);
    ck("R10 boot no wait", in_recover, 1'b0);
    deep_stby = 0;
    cyc(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule